// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable cell of a lookup-table fabric. A 16-bit truth table and a few static configuration bits set what the cell does. In general logic mode it evaluates any function of four inputs. In arithmetic mode the table splits into two three-input halves that form a sum bit and a carry bit. In counter mode the register output feeds back into the table, so a chain of cells counts up or down.

A dedicated carry chain (carry in, carry out) and a cascade chain (cascade in, cascade out) let neighbouring cells build adders, counters and wide AND/OR decoders. Every cell has one flip-flop with clock enable, a synchronous active-low reset, and asynchronous clear and preset. Two packing options let the flip-flop capture a data input directly, so that the table and the register serve unrelated logic. Each of the two outputs, one toward local routing and one toward global routing, selects on its own between the combinational result and the register.

Top module: `lgc_cell`

## Requirements
- R1: In general mode (cfg_mode=2'b00, cfg_pack=2'b00) the combinational result is cfg_lut[{s, din[2], din[1], din[0]}], where s is din[3] when cfg_d3_cin=0 and cin when cfg_d3_cin=1.
- R2: When cfg_casc_en=1, casc_out is the table output ANDed with casc_in (cfg_casc_or=0) or ORed with it (cfg_casc_or=1). When cfg_casc_en=0, casc_in has no effect: it is replaced by 1 for AND and 0 for OR. The combinational result on the outputs is casc_out.
- R3: out_local shows the register when cfg_local_reg=1 and the combinational result when it is 0. out_global does the same under cfg_global_reg, independently of out_local.
- R4: With cfg_pack=2'b01 in general mode the register captures din[3], and the table sees the index bit 3 as 0 (cfg_d3_cin=0) or cin (cfg_d3_cin=1).
- R5: With cfg_pack=2'b10 in general mode the table keeps the full four-input index of R1, and the register captures din[3].
- R6: In arithmetic mode (cfg_mode=2'b01) with i={cin, din[1], din[0]}, the result is cfg_lut[i] and cout is cfg_lut[8+i]. In general mode cout is 0.
- R7: In counter mode (cfg_mode=2'b10) with i={cin, din[1], q}, the next count bit is cfg_lut[i] and cout is cfg_lut[8+i]. din[0] enables counting, din[1] is the direction as seen by the table, din[2]=1 loads din[3] synchronously, and the register holds when din[0]=0 and din[2]=0.
- R8: When ena=0, a clock edge leaves the register unchanged.
- R9: aclr=1 forces the register to 0 and apre=1 forces it to 1, at once and without a clock edge, whatever the state of ena. Clear wins when both are high.
- R10: With rst_n=0 and no asynchronous control active, a rising clock edge sets the register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| ena | input | 1 | Clock enable for register updates |
| aclr | input | 1 | Asynchronous clear, active high, highest priority |
| apre | input | 1 | Asynchronous preset, active high |
| cfg_lut | input | 16 | Truth table |
| cfg_mode | input | 2 | 00 general, 01 arithmetic, 10 counter, 11 as general |
| cfg_pack | input | 2 | 00 none, 01 three-input table with din[3] to register, 10 four-input table with din[3] to register, 11 as none |
| cfg_d3_cin | input | 1 | Takes cin instead of din[3] as table index bit 3 |
| cfg_casc_en | input | 1 | Cascade chain enable |
| cfg_casc_or | input | 1 | Cascade operator: 0 AND, 1 OR |
| cfg_local_reg | input | 1 | out_local source: 1 register, 0 combinational |
| cfg_global_reg | input | 1 | out_global source: 1 register, 0 combinational |
| din | input | 4 | Data inputs; in counter mode: enable, direction, load, load data |
| cin | input | 1 | Carry in from the previous cell |
| casc_in | input | 1 | Cascade in from the previous cell |
| cout | output | 1 | Carry out to the next cell |
| casc_out | output | 1 | Cascade out, also the combinational result |
| out_local | output | 1 | Output toward local routing |
| out_global | output | 1 | Output toward global routing |

## Verification
The hardest case to reach is counter mode, where the register feeds the table and the carry chain ties cells together. A single cell cannot show that a count wraps or reverses across bits. The bench therefore builds a four-cell chain next to the main instance. It loads a value through din[2], counts up across the 15-to-0 wrap, reverses direction through 0 to 15, and then drops the count enable. The packing options get a similar treatment: the two outputs are set to different sources and the bench picks a din[3] that makes the register and the table result differ, so a wrong data path shows at the ports.

// File: rtl/lgc_pkg.sv
// Shared encodings for the logic cell: operating modes and register-packing options.
package lgc_pkg;
    typedef enum logic [1:0] {
        LGC_GENERAL = 2'b00,
        LGC_ARITH   = 2'b01,
        LGC_COUNT   = 2'b10,
        LGC_RSVD    = 2'b11
    } lgc_mode_e;

    typedef enum logic [1:0] {
        PACK_NONE    = 2'b00,
        PACK_BYPASS3 = 2'b01,
        PACK_SHARE4  = 2'b10,
        PACK_RSVD    = 2'b11
    } lgc_pack_e;
endpackage

// File: rtl/lgc_lut_eval.sv
// Table evaluation for one cell. In general mode it indexes the whole table.
// In arithmetic and counter modes it indexes the low half for the primary
// output and the high half for the carry.
// Assumes K >= 4: in counter mode the register takes the place of the lowest
// index bit, and the data inputs carry the counter controls.
module lgc_lut_eval
    import lgc_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] cfg_lut,
    input  lgc_mode_e         mode,
    input  lgc_pack_e         pack,
    input  logic              d3_cin,
    input  logic [K-1:0]      din,
    input  logic              cin,
    input  logic              q,
    output logic              prim,
    output logic              carry
);
    localparam int HALF_W = K - 1;

    logic            top_bit;
    logic [K-1:0]    full_idx;
    logic [HALF_W-1:0] half_idx;

    // Pick the source of the top index bit for the full table.
    always_comb begin
        if (pack == PACK_BYPASS3)
            top_bit = d3_cin ? cin : 1'b0;
        else
            top_bit = d3_cin ? cin : din[K-1];
        full_idx = {top_bit, din[K-2:0]};
    end

    // Build the three-input index for the split-table modes.
    always_comb begin
        if (mode == LGC_COUNT)
            half_idx = {cin, din[K-3:1], q};
        else
            half_idx = {cin, din[K-3:0]};
    end

    // Read the primary output and the carry for the current mode.
    always_comb begin
        if (mode == LGC_ARITH || mode == LGC_COUNT) begin
            prim  = cfg_lut[{1'b0, half_idx}];
            carry = cfg_lut[{1'b1, half_idx}];
        end else begin
            prim  = cfg_lut[full_idx];
            carry = 1'b0;
        end
    end
endmodule

// File: rtl/lgc_cascade.sv
// Cascade stage: joins the table output with the incoming cascade through AND
// or OR. A disabled cascade input is replaced by the identity of the operator.
module lgc_cascade (
    input  logic lut_in,
    input  logic casc_in,
    input  logic casc_en,
    input  logic casc_or,
    output logic casc_out
);
    logic eff_in;

    // Replace an unused cascade input with the identity value, then combine.
    always_comb begin
        eff_in   = casc_en ? casc_in : ~casc_or;
        casc_out = casc_or ? (lut_in | eff_in) : (lut_in & eff_in);
    end
endmodule

// File: rtl/lgc_ff.sv
// Cell register. Asynchronous clear beats asynchronous preset, and both beat
// the clock. Synchronous active-low reset comes next, then the update enable.
// Assumes that preset is not held high while clear is released; the preset
// then takes effect at the next clock edge.
module lgc_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic aclr,
    input  logic apre,
    input  logic upd,
    input  logic d_in,
    output logic q
);
    // Register with async clear/preset and a gated synchronous update.
    always_ff @(posedge clk or posedge aclr or posedge apre) begin
        if (aclr)
            q <= 1'b0;
        else if (apre)
            q <= 1'b1;
        else if (!rst_n)
            q <= 1'b0;
        else if (upd)
            q <= d_in;
    end
endmodule

// File: rtl/lgc_cell.sv
// Configurable logic cell: table evaluation, cascade stage, register with a
// data-source mux for packing and counter load, and two output selectors.
// Assumes the configuration inputs are static while the cell is in use.
module lgc_cell
    import lgc_pkg::*;
#(
    parameter int K = 4,
    localparam int LUT_BITS = 1 << K
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ena,
    input  logic                aclr,
    input  logic                apre,
    input  logic [LUT_BITS-1:0] cfg_lut,
    input  logic [1:0]          cfg_mode,
    input  logic [1:0]          cfg_pack,
    input  logic                cfg_d3_cin,
    input  logic                cfg_casc_en,
    input  logic                cfg_casc_or,
    input  logic                cfg_local_reg,
    input  logic                cfg_global_reg,
    input  logic [K-1:0]        din,
    input  logic                cin,
    input  logic                casc_in,
    output logic                cout,
    output logic                casc_out,
    output logic                out_local,
    output logic                out_global
);
    lgc_mode_e mode;
    lgc_pack_e pack;
    logic      lut_prim;
    logic      q_r;
    logic      d_next;
    logic      upd;

    // Map the raw configuration onto the package encodings.
    always_comb begin
        mode = lgc_mode_e'(cfg_mode);
        pack = lgc_pack_e'(cfg_pack);
    end

    lgc_lut_eval #(.K(K)) u_eval (
        .cfg_lut (cfg_lut),
        .mode    (mode),
        .pack    (pack),
        .d3_cin  (cfg_d3_cin),
        .din     (din),
        .cin     (cin),
        .q       (q_r),
        .prim    (lut_prim),
        .carry   (cout)
    );

    lgc_cascade u_casc (
        .lut_in   (lut_prim),
        .casc_in  (casc_in),
        .casc_en  (cfg_casc_en),
        .casc_or  (cfg_casc_or),
        .casc_out (casc_out)
    );

    // Choose the register data: packed bypass, counter load, or table result.
    always_comb begin
        unique case (mode)
            LGC_COUNT: d_next = din[2] ? din[K-1] : casc_out;
            LGC_ARITH: d_next = casc_out;
            default:   d_next = (pack == PACK_BYPASS3 || pack == PACK_SHARE4)
                                ? din[K-1] : casc_out;
        endcase
    end

    // Gate updates with the clock enable, and in counter mode with count or load.
    always_comb begin
        upd = ena && ((mode != LGC_COUNT) || din[0] || din[2]);
    end

    lgc_ff u_ff (
        .clk   (clk),
        .rst_n (rst_n),
        .aclr  (aclr),
        .apre  (apre),
        .upd   (upd),
        .d_in  (d_next),
        .q     (q_r)
    );

    // Each output selects its source on its own.
    always_comb begin
        out_local  = cfg_local_reg  ? q_r : casc_out;
        out_global = cfg_global_reg ? q_r : casc_out;
    end
endmodule

// File: rtl/lgc_cell_chk.sv
// Property checker for the logic cell, attached to every instance by bind.
module lgc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ena,
    input logic       aclr,
    input logic       apre,
    input logic [1:0] cfg_mode,
    input logic       cfg_casc_en,
    input logic       cfg_casc_or,
    input logic       cfg_local_reg,
    input logic       cfg_global_reg,
    input logic [3:0] din,
    input logic       cout,
    input logic       casc_out,
    input logic       out_local,
    input logic       out_global,
    input logic       lut_prim,
    input logic       q_r
);
    // Clear forces the register low whenever it is sampled high.
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        aclr |-> (q_r == 1'b0));

    // Preset forces the register high once clear has been low for a cycle.
    assert_preset_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apre && !aclr && $past(!aclr)) |-> (q_r == 1'b1));

    // With the clock enable low, the register keeps its value.
    assert_hold_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ena) && $past(!aclr) && $past(!apre) && !aclr && !apre)
        |-> (q_r == $past(q_r)));

    // Counter mode without count or load keeps the register value.
    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_mode == 2'b10) && $past(!din[0]) && $past(!din[2])
         && $past(!aclr) && $past(!apre) && !aclr && !apre)
        |-> (q_r == $past(q_r)));

    // A synchronous load in counter mode captures the load data.
    assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ena) && $past(cfg_mode == 2'b10) && $past(din[2])
         && $past(!aclr) && $past(!apre) && !aclr && !apre)
        |-> (q_r == $past(din[3])));

    // General mode drives no carry.
    assert_no_carry_general_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00) |-> (cout == 1'b0));

    // A disabled AND cascade passes the table output straight through.
    assert_casc_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_casc_en && !cfg_casc_or) |-> (casc_out == lut_prim));

    // Output selectors route the register or the combinational result.
    assert_local_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_local_reg |-> (out_local == q_r));
    assert_global_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_global_reg |-> (out_global == casc_out));
endmodule

bind lgc_cell lgc_cell_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ena            (ena),
    .aclr           (aclr),
    .apre           (apre),
    .cfg_mode       (cfg_mode),
    .cfg_casc_en    (cfg_casc_en),
    .cfg_casc_or    (cfg_casc_or),
    .cfg_local_reg  (cfg_local_reg),
    .cfg_global_reg (cfg_global_reg),
    .din            (din),
    .cout           (cout),
    .casc_out       (casc_out),
    .out_local      (out_local),
    .out_global     (out_global),
    .lut_prim       (lut_prim),
    .q_r            (q_r)
);

// File: tb/test_lgc_cell.sv
// Bench: a table of combinational vectors on one cell, then directed register
// tests, then a four-cell chain used as an adder and as an up/down counter.
module test_lgc_cell;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // Main cell stimulus
    logic        rst_n = 1'b0, ena = 1'b1, aclr = 1'b0, apre = 1'b0;
    logic [15:0] cfg_lut = 16'h0;
    logic [1:0]  cfg_mode = 2'b00, cfg_pack = 2'b00;
    logic        cfg_d3_cin = 1'b0, cfg_casc_en = 1'b0, cfg_casc_or = 1'b0;
    logic        cfg_local_reg = 1'b0, cfg_global_reg = 1'b0;
    logic [3:0]  din = 4'h0;
    logic        cin = 1'b0, casc_in = 1'b0;
    logic        cout, casc_out, out_local, out_global;

    lgc_cell i_lgc_cell (
        .clk(clk), .rst_n(rst_n), .ena(ena), .aclr(aclr), .apre(apre),
        .cfg_lut(cfg_lut), .cfg_mode(cfg_mode), .cfg_pack(cfg_pack),
        .cfg_d3_cin(cfg_d3_cin), .cfg_casc_en(cfg_casc_en), .cfg_casc_or(cfg_casc_or),
        .cfg_local_reg(cfg_local_reg), .cfg_global_reg(cfg_global_reg),
        .din(din), .cin(cin), .casc_in(casc_in),
        .cout(cout), .casc_out(casc_out), .out_local(out_local), .out_global(out_global)
    );

    // Four-cell chain
    logic [15:0] ch_lut = 16'h0;
    logic [1:0]  ch_mode = 2'b01;
    logic        ch_cin0 = 1'b0;
    logic [3:0]  ch_d [4];
    logic [4:0]  ch_c;
    logic [3:0]  ch_cas, ch_loc, ch_glb;
    assign ch_c[0] = ch_cin0;

    for (genvar g = 0; g < 4; g++) begin : g_chain
        lgc_cell u_cell (
            .clk(clk), .rst_n(rst_n), .ena(1'b1), .aclr(1'b0), .apre(1'b0),
            .cfg_lut(ch_lut), .cfg_mode(ch_mode), .cfg_pack(2'b00),
            .cfg_d3_cin(1'b0), .cfg_casc_en(1'b0), .cfg_casc_or(1'b0),
            .cfg_local_reg(1'b0), .cfg_global_reg(1'b1),
            .din(ch_d[g]), .cin(ch_c[g]), .casc_in(1'b0),
            .cout(ch_c[g+1]), .casc_out(ch_cas[g]),
            .out_local(ch_loc[g]), .out_global(ch_glb[g])
        );
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  pack;
        logic        d3c;
        logic        cen;
        logic        cor;
        logic [15:0] lut;
        logic [3:0]  d;
        logic        ci;
        logic        cas;
        logic        exp_y;
        logic        exp_co;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h6996, 4'b1011, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1},
        '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 16'h6996, 4'b1011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},
        '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 16'h6996, 4'b1011, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},
        '{2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 16'h8000, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 16'h8000, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},
        '{2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 16'h0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h8000, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},
        '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 16'hE896, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 16'hE896, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6},
        '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 16'hE896, 4'b1100, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},
        '{2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 16'h6996, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 16'h6996, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'hE896, 4'b0011, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}
    };

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd4: return "R4";
            4'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Move to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int chain_val();
        return int'({ch_glb[3], ch_glb[2], ch_glb[1], ch_glb[0]});
    endfunction

    task automatic set_counter(input logic en, input logic up, input logic ld, input logic [3:0] val);
        for (int i = 0; i < 4; i++) ch_d[i] = {val[i], ld, up, en};
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ch_d[i] = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        // Reset state: register reads 0 through out_local.
        cfg_local_reg = 1'b1;
        chk("R10 reset state", int'(out_local), 0);
        rst_n = 1'b1;
        cfg_local_reg = 1'b0;

        // Table walk: combinational result and carry.
        for (int v = 0; v < NV; v++) begin
            cfg_mode = VT[v].mode;  cfg_pack = VT[v].pack;  cfg_d3_cin = VT[v].d3c;
            cfg_casc_en = VT[v].cen; cfg_casc_or = VT[v].cor; cfg_lut = VT[v].lut;
            din = VT[v].d; cin = VT[v].ci; casc_in = VT[v].cas;
            #1;
            chk({tag(VT[v].req), " table result"}, int'(out_local), int'(VT[v].exp_y));
            chk({tag(VT[v].req), " table carry"}, int'(cout), int'(VT[v].exp_co));
        end

        // Async preset and clear, clear has priority (R9).
        cfg_mode = 2'b00; cfg_pack = 2'b00; cfg_casc_en = 1'b0; cfg_casc_or = 1'b0;
        cfg_d3_cin = 1'b0; cin = 1'b0; cfg_local_reg = 1'b1; ena = 1'b0;
        @(posedge clk); #1;
        apre = 1'b1; #1;
        chk("R9 preset immediate", int'(out_local), 1);
        aclr = 1'b1; #1;
        chk("R9 clear over preset", int'(out_local), 0);
        apre = 1'b0; #1;
        aclr = 1'b0; ena = 1'b1;

        // Packing option 01: register takes din[3], table is 3-input (R4, R3).
        cfg_pack = 2'b01; cfg_lut = 16'h6996; din = 4'b1000;
        cfg_local_reg = 1'b1; cfg_global_reg = 1'b0;
        tick();
        chk("R4 packed register gets din[3]", int'(out_local), 1);
        chk("R3 global shows table while local shows register", int'(out_global), 0);

        // Clock enable low holds the register (R8).
        ena = 1'b0; din = 4'b0000;
        tick();
        chk("R8 hold with ena low", int'(out_local), 1);
        ena = 1'b1;

        // Synchronous reset clears a set register (R10).
        rst_n = 1'b0; din = 4'b1000;
        tick();
        chk("R10 sync reset", int'(out_local), 0);
        rst_n = 1'b1;

        // Packing option 10: 4-input table, register still takes din[3] (R5).
        cfg_pack = 2'b10; din = 4'b1001;
        tick();
        chk("R5 shared-input register", int'(out_local), 1);
        chk("R5 four-input table result", int'(casc_out), 0);

        // Swap the output sources (R3).
        cfg_local_reg = 1'b0; cfg_global_reg = 1'b1; #1;
        chk("R3 local shows table", int'(out_local), 0);
        chk("R3 global shows register", int'(out_global), 1);

        // Clear held over a clock edge with data 1 (R9).
        aclr = 1'b1; din = 4'b1000;
        tick();
        chk("R9 clear over clock", int'(out_global), 0);
        aclr = 1'b0;

        // Four-bit ripple adder on the chain (R6).
        ch_mode = 2'b01; ch_lut = 16'hE896; ch_cin0 = 1'b0;
        for (int p = 0; p < 4; p++) begin
            int a, b;
            case (p)
                0: begin a = 5;  b = 3; end
                1: begin a = 15; b = 1; end
                2: begin a = 9;  b = 6; end
                default: begin a = 0; b = 0; end
            endcase
            for (int i = 0; i < 4; i++) ch_d[i] = {2'b00, b[i], a[i]};
            #1;
            chk("R6 chain sum", int'(ch_cas), (a + b) % 16);
            chk("R6 chain carry out", int'(ch_c[4]), (a + b) / 16);
        end

        // Up/down counter on the chain (R7).
        ch_mode = 2'b10; ch_lut = 16'h905A; ch_cin0 = 1'b1;
        set_counter(1'b0, 1'b1, 1'b1, 4'd14);
        tick();
        chk("R7 counter load", chain_val(), 14);
        set_counter(1'b1, 1'b1, 1'b0, 4'd0);
        tick();
        chk("R7 count up", chain_val(), 15);
        repeat (2) tick();
        chk("R7 count up across wrap", chain_val(), 1);
        set_counter(1'b1, 1'b0, 1'b0, 4'd0);
        repeat (2) tick();
        chk("R7 count down across wrap", chain_val(), 15);
        set_counter(1'b0, 1'b1, 1'b0, 4'd0);
        repeat (2) tick();
        chk("R7 count enable low holds", chain_val(), 15);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule